// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets synchronous logic read and write an external asynchronous static RAM that holds 131,072 bytes behind 17 address lines and an 8-bit bidirectional data bus. The host side uses a valid/ready handshake. Each request carries a read/write flag, an address and, for writes, a data byte. Read data comes back with a one-cycle valid strobe. On the memory side the block drives active-low chip-enable, output-enable and write-enable strobes and the address bus. The data bus is split into an outgoing value, an incoming value and a drive-enable.

Every phase of an access is stretched to a whole number of clock periods. The length comes from a minimum time in picoseconds and the clock period, rounded up, with a floor of one cycle. A read holds chip enable and output enable low for the access phase. The bus is sampled on the last edge of that phase, and then a turnaround phase lets the memory release the bus. A write keeps output enable high throughout, so the short write pulse is enough. Data is driven only while output enable is high, and it stays driven for one recovery cycle after write enable rises. Address and write data are captured when the request is accepted and held until the access ends.

Top module: `sram_async_ctrl`

## Requirements
- R1: During and after reset, with no request, all three strobes are high (1), the data drive-enable is 0, request-ready is 1 and the read-valid strobe is 0.
- R2: A read holds chip enable and output enable low, with write enable high, for ACC cycles. It samples the incoming bus on the last edge of that phase and raises read-valid for exactly one cycle, the cycle after the access phase.
- R3: A write holds chip enable and write enable low, with output enable high and the data driven, for exactly WPC cycles. WPC is the larger of the rounded pulse-width and data-setup times.
- R4: After write enable rises, the same write data and address stay driven for one recovery cycle, with chip enable high.
- R5: Output enable is never low while the block drives the data bus.
- R6: Output enable and write enable are never low while chip enable is high, and they are never low together.
- R7: Request-ready falls on the edge that accepts a request and stays low for ACC+TRN cycles after a read and WPC+1 cycles after a write.
- R8: While chip enable is low the address bus is stable and equals the accepted request address.
- R9: Each phase length in cycles is ceil(time_ps / CLK_PERIOD_PS), with a minimum of 1. With the defaults at 5000 ps this gives ACC=2, WPC=2 and TRN=1.
- R10: A read returns the byte most recently written to that address, across the whole address range (0 and 0x1FFFF included) and for back-to-back mixed requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_in | input | DATA_W | Data seen on the memory bus |
| mem_dq_oe | output | 1 | Block drives the data bus |

## Verification
The memory model in the bench returns a garbage byte until output enable has been low for ACC-1 edges. A design that samples one edge early therefore returns the wrong byte. The model measures the width of every write pulse and checks that data is still driven in the cycle after write enable rises, which catches a pulse that is too short or an early release of the bus. Ready-low durations are counted for each request, which exposes a missing turnaround or recovery cycle. Writes and reads to the two ends of the address space catch a truncated address register.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_ACC = 3'd1,
      ST_RD_TRN = 3'd2,
      ST_WR_PLS = 3'd3,
      ST_WR_REC = 3'd4
   } sram_state_e;

   function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned per_ps);
      int unsigned c;
      c = (t_ps + per_ps - 1) / per_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
   import sram_ctrl_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int ACC_CYC = 2,
   parameter int WP_CYC  = 2,
   parameter int TRN_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   output logic accept,
   output logic sample,
   output logic ready,
   output logic ce_n,
   output logic oe_n,
   output logic we_n,
   output logic dq_oe
);
   localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TRN_LD = CNT_W'(TRN_CYC - 1);

   sram_state_e      st_q, st_d;
   logic             t_load, t_done;
   logic [CNT_W-1:0] t_val;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
   );

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      accept = 1'b0;
      sample = 1'b0;
      unique case (st_q)
         ST_IDLE: if (req_valid) begin
            accept = 1'b1;
            t_load = 1'b1;
            t_val  = req_write ? WP_LD : ACC_LD;
            st_d   = req_write ? ST_WR_PLS : ST_RD_ACC;
         end
         ST_RD_ACC: if (t_done) begin
            sample = 1'b1;
            t_load = 1'b1;
            t_val  = TRN_LD;
            st_d   = ST_RD_TRN;
         end
         ST_RD_TRN: if (t_done) st_d = ST_IDLE;
         ST_WR_PLS: if (t_done) st_d = ST_WR_REC;
         ST_WR_REC: st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign ready = (st_q == ST_IDLE);
   assign ce_n  = !((st_q == ST_RD_ACC) || (st_q == ST_WR_PLS));
   assign oe_n  = (st_q != ST_RD_ACC);
   assign we_n  = (st_q != ST_WR_PLS);
   assign dq_oe = (st_q == ST_WR_PLS) || (st_q == ST_WR_REC);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              sample,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_in,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         dq_out <= '0;
      end else if (accept) begin
         addr   <= req_addr;
         dq_out <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= sample;
         if (sample) rsp_rdata <= dq_in;
      end
   end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_PS = 5000,
   parameter int T_ACCESS_PS   = 10000,
   parameter int T_WPULSE_PS   = 8000,
   parameter int T_DSETUP_PS   = 6000,
   parameter int T_TURN_PS     = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);
   localparam int ACC_CYC = cycles_for(T_ACCESS_PS, CLK_PERIOD_PS);
   localparam int WP_CYC  = max2(cycles_for(T_WPULSE_PS, CLK_PERIOD_PS),
                                 cycles_for(T_DSETUP_PS, CLK_PERIOD_PS));
   localparam int TRN_CYC = cycles_for(T_TURN_PS, CLK_PERIOD_PS);
   localparam int MAX_CYC = max2(max2(ACC_CYC, WP_CYC), TRN_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: widths must be positive");
      end
      if (CLK_PERIOD_PS < 1) begin : g_bad_period
         $error("sram_async_ctrl: clock period must be positive");
      end
   endgenerate

   logic accept, sample;

   sram_ctrl_fsm #(
      .CNT_W(CNT_W), .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .TRN_CYC(TRN_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .accept(accept), .sample(sample), .ready(req_ready),
      .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
   );

   sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .accept(accept), .sample(sample),
      .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
      .addr(mem_addr), .dq_out(mem_dq_out),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);
   AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && !mem_oe_n)); // R5
   AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_oe_n && mem_we_n)); // R6
   AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n)); // R6
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R8
   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R2
   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R7
   AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe); // R3
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr))); // R4
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
   localparam int AW = 17;
   localparam int DW = 8;
   localparam int PER = 5000;
   localparam int ACC_C = (10000 + PER - 1) / PER;
   localparam int WPA   = (8000 + PER - 1) / PER;
   localparam int WPB   = (6000 + PER - 1) / PER;
   localparam int WP_C  = (WPA > WPB) ? WPA : WPB;
   localparam int TRN_C = (5000 + PER - 1) / PER;
   localparam logic [7:0] JUNK = 8'h5A;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;

   int checks = 0, fails = 0;
   logic [7:0] mem_model [int];
   logic [7:0] exp_mem [int];
   logic [7:0] exp_q [$];
   int rd_age = 0, wp_len = 0;
   logic [AW-1:0] cur_addr = '0, wr_addr = '0;
   logic [7:0] wr_data = '0;

   always #2.5 clk = ~clk;

   sram_async_ctrl u_dut (.*);

   function automatic logic [7:0] rd_mem(input logic [AW-1:0] a);
      return mem_model.exists(int'(a)) ? mem_model[int'(a)] : 8'h00;
   endfunction

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && rd_age >= ACC_C - 1) ? rd_mem(mem_addr) : JUNK;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: read age, write pulse width, address tracking
   always @(posedge clk) begin
      if (rst_n) begin
         if (!mem_ce_n && !mem_oe_n) rd_age = rd_age + 1; else rd_age = 0;
         if (!mem_ce_n) chk(mem_addr == cur_addr, "R8 addr", int'(mem_addr), int'(cur_addr));
         if (!mem_we_n) begin
            wp_len++;
            wr_addr = mem_addr;
            wr_data = mem_dq_out;
         end else if (wp_len != 0) begin
            chk(wp_len == WP_C, "R3 pulse width", wp_len, WP_C);
            chk(mem_dq_oe && mem_dq_out == wr_data && mem_addr == wr_addr && mem_ce_n,
                "R4 recovery hold", int'(mem_dq_out), int'(wr_data));
            mem_model[int'(wr_addr)] = wr_data;
            wp_len = 0;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk(0, "R2 unexpected rsp", int'(rsp_rdata), 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(rsp_rdata == e, "R10 read data", int'(rsp_rdata), int'(e));
         end
      end
      if (rst_n && !mem_oe_n && mem_dq_oe) chk(0, "R5 contention", 1, 0);
   end

   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [7:0] d);
      int n;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      cur_addr = a;
      if (wr) exp_mem[int'(a)] = d;
      else exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
      @(negedge clk);
      req_valid = 0; req_addr = ~a; req_wdata = ~d;
      if (!wr) chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      else chk(!mem_ce_n && mem_oe_n && !mem_we_n && mem_dq_oe, "R3 write strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b010);
      n = 0;
      while (!req_ready) begin n++; @(negedge clk); end
      chk(n == (wr ? WP_C + 1 : ACC_C + TRN_C), "R7 R9 busy cycles", n, wr ? WP_C + 1 : ACC_C + TRN_C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
          "R1 reset state", {req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 idle after reset", {req_ready, mem_ce_n}, 2'b11);
      chk(ACC_C == 2 && WP_C == 2 && TRN_C == 1, "R9 defaults", ACC_C * 100 + WP_C * 10 + TRN_C, 221);
      do_req(0, 17'h00123, 0);
      do_req(1, 17'h00000, 8'h11);
      do_req(1, 17'h1FFFF, 8'hC3);
      do_req(0, 17'h00000, 0);
      do_req(0, 17'h1FFFF, 0);
      for (int i = 0; i < 8; i++) do_req(1, AW'(17'h10000 + i * 257), 8'(8'hA0 + i * 3));
      for (int i = 7; i >= 0; i--) do_req(0, AW'(17'h10000 + i * 257), 0);
      do_req(1, 17'h0AAAA, 8'h3C);
      do_req(0, 17'h0AAAA, 0);
      do_req(1, 17'h0AAAA, 8'hF0);
      do_req(1, 17'h0AAAA, 8'h0F);
      do_req(0, 17'h0AAAA, 0);
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all responses", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule